// File: doc/BRIEF.md
# Late Branch Resolution and Redirect Control

This block decides branches for a five-stage in-order pipeline and steers instruction fetch. While a branch sits in the execute stage, the block computes its target address and its equality condition. It keeps these values in its own execute-to-memory register. When the branch reaches the memory stage, the block decides whether the branch is taken. On a taken branch it loads the fetch PC with the target and squashes the three younger stages.

The block also owns the fetch PC. It advances the PC by one instruction step each cycle. A data-hazard stall holds the PC. When a data-memory read fails, the block freezes the whole pipeline, and a bubble is inserted into write-back while the read is retried. Instruction memory, data memory and the ALU datapath sit outside the block.

Top module: `brx_redirect_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `pc_o` is 0 and redirect, the three flush outputs, freeze and bubble are all low while the execute opcode is NOP (code 0).
- R2: When opcode JMP (code 5) is in execute, the target is latched as `ex_dst_val_i + pc_o` of that cycle. In the next cycle `redirect_o` is high and `next_pc_o` equals that target.
- R3: JEQ (code 6) is taken one cycle later only if `ex_src1_val_i - ex_src2_val_i` is zero. JNE (code 7) is taken only if the two values differ.
- R4: `flush_if_o`, `flush_id_o` and `flush_ex_o` are high in exactly the cycles of a taken branch. The instruction in execute in that cycle is discarded, so even a branch there causes no redirect in the following cycle.
- R5: In the cycle after a taken branch, `pc_o` equals the target.
- R6: With no taken branch, no stall and no freeze, `pc_o` rises by 4 each cycle, and `next_pc_o` shows the PC value for the next cycle.
- R7: `hazard_stall_i` holds `pc_o`, but a taken branch in the same cycle wins: it redirects and flushes regardless of the stall.
- R8: While `dmem_rd_fail_i` is high, `freeze_o` and `wb_bubble_o` are high, `pc_o` holds, and no redirect or flush occurs. A branch waiting in the memory stage is kept and takes effect in the first cycle after the failure clears.
- R9: Opcodes ADD (1), SUB (2), LOAD (3) and STORE (4) never cause a redirect, even when the two source values are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ex_op_i | input | 3 | Opcode of the instruction in execute |
| ex_src1_val_i | input | XLEN | First source operand value in execute |
| ex_src2_val_i | input | XLEN | Second source operand value in execute |
| ex_dst_val_i | input | XLEN | Value of the destination register, used as the branch offset |
| dmem_rd_fail_i | input | 1 | Data-memory read failed this cycle |
| hazard_stall_i | input | 1 | Data-hazard stall request holding fetch |
| pc_o | output | XLEN | Current fetch PC |
| next_pc_o | output | XLEN | PC value loaded at the next edge |
| redirect_o | output | 1 | Fetch is redirected to the branch target |
| flush_if_o | output | 1 | Replace the fetch stage with a NOP |
| flush_id_o | output | 1 | Replace the decode stage with a NOP |
| flush_ex_o | output | 1 | Replace the execute stage with a NOP |
| freeze_o | output | 1 | Hold every stage from fetch through memory |
| wb_bubble_o | output | 1 | Write a NOP into write-back |

## Verification
The assertions check a set of cycle-to-cycle rules on every cycle. After a taken branch the PC holds the latched target. A free-running cycle adds exactly one step to the PC. A stall or freeze holds the PC. A freeze keeps the branch register unchanged, and a squash leaves it empty. Some behaviour can only be shown by the bench's scenarios. These are: whether each branch kind is taken for equal and unequal operands, that the target combines the offset with the PC of the execute cycle, and that a branch parked behind a read failure fires exactly once after the failure clears. The scenarios also cover a second branch lost in the squash shadow of the first, and a stall that the redirect overrides.

// File: rtl/brx_pkg.sv
// Package: shared opcode encoding for the branch redirect block.
// Assumes a 3-bit opcode field decoded identically by the whole pipeline.
package brx_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4,
        OP_JMP   = 3'd5,
        OP_JEQ   = 3'd6,
        OP_JNE   = 3'd7
    } op_e;

    // True for the three control-transfer opcodes.
    function automatic logic is_branch(op_e op);
        return (op == OP_JMP) || (op == OP_JEQ) || (op == OP_JNE);
    endfunction

endpackage

// File: rtl/brx_ex_eval.sv
// Module: brx_ex_eval
// Execute-stage branch evaluation. It forms the branch target as the
// destination-register value plus the current fetch PC, and it reports
// whether the two source operands subtract to zero.
// Assumes the operands already carry any forwarded values.
module brx_ex_eval
    import brx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_e             op_i,
    input  logic [XLEN-1:0] src1_i,
    input  logic [XLEN-1:0] src2_i,
    input  logic [XLEN-1:0] dst_val_i,
    input  logic [XLEN-1:0] pc_i,
    output op_e             br_op_o,
    output logic            zero_o,
    output logic [XLEN-1:0] target_o
);

    logic [XLEN-1:0] diff;

    // Condition and target arithmetic for the instruction in execute.
    always_comb begin
        diff     = src1_i - src2_i;
        zero_o   = (diff == '0);
        target_o = dst_val_i + pc_i;
        br_op_o  = is_branch(op_i) ? op_i : OP_NOP;
    end

endmodule

// File: rtl/brx_exmem_reg.sv
// Module: brx_exmem_reg
// Branch slice of the execute-to-memory register. It holds its contents
// during a freeze and loads a NOP when execute is squashed.
// Assumes the hold input already has priority over the squash input.
module brx_exmem_reg
    import brx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_i,
    input  logic            squash_i,
    input  op_e             op_i,
    input  logic            zero_i,
    input  logic [XLEN-1:0] target_i,
    output op_e             op_o,
    output logic            zero_o,
    output logic [XLEN-1:0] target_o
);

    // Register update: reset, hold on freeze, bubble on squash, else load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_o     <= OP_NOP;
            zero_o   <= 1'b0;
            target_o <= '0;
        end else if (hold_i) begin
            op_o     <= op_o;
            zero_o   <= zero_o;
            target_o <= target_o;
        end else if (squash_i) begin
            op_o     <= OP_NOP;
            zero_o   <= 1'b0;
            target_o <= '0;
        end else begin
            op_o     <= op_i;
            zero_o   <= zero_i;
            target_o <= target_i;
        end
    end

    // R8: a branch parked in the memory stage survives the freeze.
    a_r8_hold_branch: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> ($stable(op_o) && $stable(target_o) && $stable(zero_o)));

    // R4: a squashed execute stage leaves nothing behind.
    a_r4_squash_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_i && !hold_i) |=> (op_o == OP_NOP));

endmodule

// File: rtl/brx_pc_unit.sv
// Module: brx_pc_unit
// Fetch PC register with its next-value select: a taken target, a hold
// for stall or freeze, or a sequential step.
// Assumes take_i is already suppressed during a freeze.
module brx_pc_unit #(
    parameter int XLEN     = 32,
    parameter int PC_STEP  = 4,
    parameter int RESET_PC = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic [XLEN-1:0] target_i,
    input  logic            stall_i,
    input  logic            freeze_i,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] pc_next_o
);

    localparam logic [XLEN-1:0] STEP_V  = XLEN'(PC_STEP);
    localparam logic [XLEN-1:0] RESET_V = XLEN'(RESET_PC);

    // Next-PC select; a redirect outranks both stall and freeze holds.
    always_comb begin
        if (take_i)
            pc_next_o = target_i;
        else if (stall_i || freeze_i)
            pc_next_o = pc_o;
        else
            pc_next_o = pc_o + STEP_V;
    end

    // PC register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_o <= RESET_V;
        else        pc_o <= pc_next_o;
    end

    // R5: the PC lands on the target after a taken branch.
    a_r5_load_target: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (pc_o == $past(target_i)));

    // R6: a free cycle moves the PC by exactly one step.
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !stall_i && !freeze_i) |=> (pc_o == $past(pc_o) + STEP_V));

    // R7: a stall or a freeze holds the PC.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && (stall_i || freeze_i)) |=> $stable(pc_o));

endmodule

// File: rtl/brx_redirect_ctrl.sv
// Module: brx_redirect_ctrl
// Top of the branch resolution block. A branch is evaluated in execute,
// carried into the memory stage, and resolved there. A taken branch
// flushes fetch, decode and execute and redirects the PC. A failed
// data read freezes all stages and inserts a write-back bubble, and
// it outranks a redirect.
// Assumes operand values arrive already forwarded, one instruction per cycle.
module brx_redirect_ctrl
    import brx_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int PC_STEP  = 4,
    parameter int RESET_PC = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      ex_op_i,
    input  logic [XLEN-1:0] ex_src1_val_i,
    input  logic [XLEN-1:0] ex_src2_val_i,
    input  logic [XLEN-1:0] ex_dst_val_i,
    input  logic            dmem_rd_fail_i,
    input  logic            hazard_stall_i,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] next_pc_o,
    output logic            redirect_o,
    output logic            flush_if_o,
    output logic            flush_id_o,
    output logic            flush_ex_o,
    output logic            freeze_o,
    output logic            wb_bubble_o
);

    op_e             ex_br_op;
    logic            ex_zero;
    logic [XLEN-1:0] ex_target;
    op_e             mem_op;
    logic            mem_zero;
    logic [XLEN-1:0] mem_target;
    logic            cond_met;
    logic            take;

    brx_ex_eval #(.XLEN(XLEN)) u_eval (
        .op_i      (op_e'(ex_op_i)),
        .src1_i    (ex_src1_val_i),
        .src2_i    (ex_src2_val_i),
        .dst_val_i (ex_dst_val_i),
        .pc_i      (pc_o),
        .br_op_o   (ex_br_op),
        .zero_o    (ex_zero),
        .target_o  (ex_target)
    );

    brx_exmem_reg #(.XLEN(XLEN)) u_exmem (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (dmem_rd_fail_i),
        .squash_i (take),
        .op_i     (ex_br_op),
        .zero_i   (ex_zero),
        .target_i (ex_target),
        .op_o     (mem_op),
        .zero_o   (mem_zero),
        .target_o (mem_target)
    );

    // Memory-stage decision; a read failure defers it.
    always_comb begin
        unique case (mem_op)
            OP_JMP:  cond_met = 1'b1;
            OP_JEQ:  cond_met = mem_zero;
            OP_JNE:  cond_met = !mem_zero;
            default: cond_met = 1'b0;
        endcase
        take = cond_met && !dmem_rd_fail_i;
    end

    brx_pc_unit #(
        .XLEN     (XLEN),
        .PC_STEP  (PC_STEP),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .target_i  (mem_target),
        .stall_i   (hazard_stall_i),
        .freeze_i  (dmem_rd_fail_i),
        .pc_o      (pc_o),
        .pc_next_o (next_pc_o)
    );

    // Control outputs toward the pipeline registers.
    always_comb begin
        redirect_o  = take;
        flush_if_o  = take;
        flush_id_o  = take;
        flush_ex_o  = take;
        freeze_o    = dmem_rd_fail_i;
        wb_bubble_o = dmem_rd_fail_i;
    end

endmodule

// File: tb/brx_redirect_ctrl_tb_top.sv
`timescale 1ns/1ps
module brx_redirect_ctrl_tb_top;

    localparam int W   = 32;
    localparam int VW  = 2*W + 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    ex_op = 3'd0;
    logic [W-1:0]  src1 = '0, src2 = '0, dstv = '0;
    logic          rd_fail = 1'b0, stall = 1'b0;
    logic [W-1:0]  pc_o, next_pc_o;
    logic          redirect_o, flush_if_o, flush_id_o, flush_ex_o, freeze_o, wb_bubble_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [VW-1:0] exp_q[$];
    string         tag_q[$];

    // reference model state
    logic [W-1:0] m_pc;
    logic [2:0]   m_op;
    logic         m_eq;
    logic [W-1:0] m_tgt;

    always #2.5 clk = ~clk;

    brx_redirect_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ex_op_i(ex_op),
        .ex_src1_val_i(src1), .ex_src2_val_i(src2), .ex_dst_val_i(dstv),
        .dmem_rd_fail_i(rd_fail), .hazard_stall_i(stall),
        .pc_o(pc_o), .next_pc_o(next_pc_o), .redirect_o(redirect_o),
        .flush_if_o(flush_if_o), .flush_id_o(flush_id_o), .flush_ex_o(flush_ex_o),
        .freeze_o(freeze_o), .wb_bubble_o(wb_bubble_o)
    );

    task automatic model_reset();
        m_pc = '0; m_op = 3'd0; m_eq = 1'b0; m_tgt = '0;
    endtask

    // Reset for two cycles; returns at a falling edge with reset released.
    task automatic do_reset();
        rst_n = 1'b0; ex_op = 3'd0; rd_fail = 1'b0; stall = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Driver: apply one cycle of stimulus, push expected outputs, advance model.
    task automatic cyc(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] d, input logic st, input logic fl, input string tag);
        logic tk;
        logic [W-1:0] nx;
        ex_op = op; src1 = a; src2 = b; dstv = d; stall = st; rd_fail = fl;
        tk = !fl && ((m_op == 3'd5) || (m_op == 3'd6 && m_eq) || (m_op == 3'd7 && !m_eq));
        nx = tk ? m_tgt : ((st || fl) ? m_pc : m_pc + 32'd4);
        exp_q.push_back({m_pc, nx, tk, tk, tk, tk, fl, fl});
        tag_q.push_back(tag);
        if (!fl) begin
            if (tk || op < 3'd5) begin
                m_op = 3'd0; m_eq = 1'b0; m_tgt = '0;
            end else begin
                m_op = op; m_eq = (a == b); m_tgt = d + m_pc;
            end
            m_pc = nx;
        end
        @(negedge clk);
    endtask

    // Monitor: pop each expected item and compare away from the edge.
    initial begin
        forever begin
            logic [VW-1:0] e, act;
            string t;
            wait (exp_q.size() > 0);
            #1;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            act = {pc_o, next_pc_o, redirect_o, flush_if_o, flush_id_o, flush_ex_o, freeze_o, wb_bubble_o};
            checks++;
            if (act !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", t, act, e);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        cyc(3'd0, 0, 0, 0, 0, 0, "R1");          // reset state
        cyc(3'd1, 1, 2, 0, 0, 0, "R6");          // sequential stepping
        cyc(3'd2, 4, 4, 0, 0, 0, "R6");
        cyc(3'd0, 0, 0, 0, 0, 0, "R6");
        cyc(3'd5, 0, 9, 32'h100, 0, 0, "R2");    // unconditional jump
        cyc(3'd0, 0, 0, 0, 0, 0, "R2");          // redirect to 0x100+pc
        cyc(3'd0, 0, 0, 0, 0, 0, "R5");          // pc at target
        cyc(3'd6, 5, 5, 32'h40, 0, 0, "R3");     // JEQ equal: taken
        cyc(3'd0, 0, 0, 0, 0, 0, "R3");
        cyc(3'd6, 5, 6, 32'h40, 0, 0, "R3");     // JEQ unequal: not taken
        cyc(3'd0, 0, 0, 0, 0, 0, "R3");
        cyc(3'd7, 8, 3, 32'h24, 0, 0, "R3");     // JNE unequal: taken
        cyc(3'd0, 0, 0, 0, 0, 0, "R3");
        cyc(3'd7, 8, 8, 32'h24, 0, 0, "R3");     // JNE equal: not taken
        cyc(3'd0, 0, 0, 0, 0, 0, "R3");
        cyc(3'd5, 0, 0, 32'h200, 0, 0, "R4");    // back-to-back jumps
        cyc(3'd5, 0, 0, 32'h300, 0, 0, "R4");    // second one squashed
        cyc(3'd0, 0, 0, 0, 0, 0, "R4");          // no redirect from it
        cyc(3'd0, 0, 0, 0, 1, 0, "R7");          // stall holds pc
        cyc(3'd0, 0, 0, 0, 1, 0, "R7");
        cyc(3'd5, 0, 0, 32'h80, 0, 0, "R7");
        cyc(3'd0, 0, 0, 0, 1, 0, "R7");          // redirect beats stall
        cyc(3'd0, 0, 0, 0, 0, 0, "R5");
        cyc(3'd6, 7, 7, 32'h20, 0, 0, "R8");     // branch then read failure
        cyc(3'd0, 0, 0, 0, 0, 1, "R8");
        cyc(3'd0, 0, 0, 0, 0, 1, "R8");
        cyc(3'd0, 0, 0, 0, 0, 0, "R8");          // deferred redirect
        cyc(3'd0, 0, 0, 0, 0, 0, "R8");          // fires once only
        cyc(3'd1, 0, 0, 0, 0, 1, "R8");          // failure with no branch
        cyc(3'd4, 3, 3, 32'h10, 0, 0, "R9");     // non-branch ops
        cyc(3'd3, 2, 2, 32'h10, 0, 0, "R9");
        cyc(3'd2, 6, 6, 32'h10, 0, 0, "R9");
        cyc(3'd0, 0, 0, 0, 0, 0, "R9");
        do_reset();
        cyc(3'd0, 0, 0, 0, 0, 0, "R1");          // reset mid-run
        wait (exp_q.size() == 0);
        #2;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule